// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block sits between external interrupt sources and a processor core. It latches three kinds of request: a reset request, a non-maskable request, and a six-bit level interrupt. It evaluates them only when the core signals an instruction boundary. At each boundary it serves at most one request, in a fixed order: reset first, then the non-maskable request, then the level interrupt. Reset and non-maskable share one exception output.

A level request updates a hardware-interrupt field (`cause_ip`) that the core reads. The request becomes an interrupt exception only when two things hold in the status word: the global enable bit is set, and the mask field shares at least one bit with the level. A level request that is blocked stays pending and is tried again at every later boundary. A level event with value zero acts as end-of-interrupt. At the next boundary it clears the field and drops the pending request.

Top module: `irq_deliver`

## Requirements
- R1: After reset, `cause_ip` is 0 and no exception output is asserted at a boundary until a request arrives.
- R2: A `rst_req` pulse makes `exc_nmirst` high during the next `boundary` cycle, exactly once.
- R3: An `nmi_req` pulse makes `exc_nmirst` high during the next `boundary` cycle that does not serve a reset, exactly once.
- R4: Priority is reset > non-maskable > level. Only one request is served per boundary, and no level request is evaluated while a reset or non-maskable request is pending.
- R5: When a pending nonzero level is evaluated at a boundary, `cause_ip` holds that level from the next cycle.
- R6: `exc_int` is high during a boundary cycle that evaluates a nonzero level, when `status[0]` (enable) is 1 and level AND `status[13:8]` (mask) is nonzero. The request is then no longer pending.
- R7: A level request that is disabled or fully masked raises no `exc_int`. It stays pending and is delivered at a later boundary once it is enabled and unmasked.
- R8: A level event with value 0 clears `cause_ip` at the next evaluation, raises no exception, and cancels the pending level request.
- R9: A level event that arrives while a level request is pending replaces the pending value.
- R10: Exception outputs are high only in `boundary` cycles, and never both in the same cycle.
- R11: Without a `boundary` strobe, `cause_ip` does not change and no exception is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| rst_req | input | 1 | Reset request event (one-cycle pulse) |
| nmi_req | input | 1 | Non-maskable request event (one-cycle pulse) |
| lvl_evt | input | 1 | Level event strobe |
| lvl_in | input | 6 | Level value; 0 means end-of-interrupt |
| status | input | 32 | Status word: bit 0 enable, bits 13:8 mask |
| boundary | input | 1 | Instruction-boundary strobe |
| cause_ip | output | 6 | Hardware-interrupt field |
| exc_int | output | 1 | Interrupt exception request (pulse) |
| exc_nmirst | output | 1 | Combined reset / non-maskable exception request (pulse) |

## Verification
The bench goes after a level that is pending but masked, and a level that is pending but disabled. A design that dropped such a request would never deliver it after the mask opens. A design that fired regardless would raise `exc_int` while the request is blocked. The bench also raises reset, non-maskable and level requests in the same cycle. A wrong priority shows as a level interrupt before the `exc_nmirst` pulses, or as a single merged pulse. Further cases are an end-of-interrupt following a pending level, two level events without a boundary between them, and events with no boundary at all. In a faulty design these show as a stale `cause_ip`, a delivery of the old value, or evaluation outside a boundary.

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int LVL_W  = 6,
  parameter int SR_W   = 32,
  parameter int IE_BIT = 0,
  parameter int IM_LSB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic             nmi_req,
  input  logic             lvl_evt,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [SR_W-1:0]  status,
  input  logic             boundary,
  output logic [LVL_W-1:0] cause_ip,
  output logic             exc_int,
  output logic             exc_nmirst
);
  localparam int IM_MSB = IM_LSB + LVL_W - 1;

  logic             p_rst, p_nmi, lvl_pend;
  logic [LVL_W-1:0] lvl_q;

  wire [LVL_W-1:0] im     = status[IM_MSB:IM_LSB];
  wire             ie     = status[IE_BIT];
  wire             hi     = p_rst | p_nmi;
  wire             lvl_go = boundary & ~hi & lvl_pend;
  wire             fire   = lvl_go & (|lvl_q) & ie & (|(lvl_q & im));
  wire             done   = lvl_go & (~(|lvl_q) | fire);

  assign exc_nmirst = boundary & hi;
  assign exc_int    = fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_rst    <= 1'b0;
      p_nmi    <= 1'b0;
      lvl_pend <= 1'b0;
      lvl_q    <= '0;
      cause_ip <= '0;
    end else begin
      if (rst_req)                   p_rst <= 1'b1;
      else if (boundary)             p_rst <= 1'b0;
      if (nmi_req)                   p_nmi <= 1'b1;
      else if (boundary && !p_rst)   p_nmi <= 1'b0;
      if (lvl_evt) begin
        lvl_pend <= 1'b1;
        lvl_q    <= lvl_in;
      end else if (done) begin
        lvl_pend <= 1'b0;
      end
      if (lvl_go) cause_ip <= lvl_q;
    end
  end
endmodule

module irq_deliver_chk #(
  parameter int LVL_W  = 6,
  parameter int SR_W   = 32,
  parameter int IE_BIT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary,
  input logic             lvl_evt,
  input logic [SR_W-1:0]  status,
  input logic [LVL_W-1:0] cause_ip,
  input logic             exc_int,
  input logic             exc_nmirst,
  input logic             p_rst,
  input logic             p_nmi,
  input logic             lvl_pend
);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_int && exc_nmirst));
  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_int || exc_nmirst) |-> boundary);
  assert_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_int |-> (!p_rst && !p_nmi));
  assert_serve_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (p_rst || p_nmi)) |-> exc_nmirst);
  assert_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_int |-> status[IE_BIT]);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_int |=> (!lvl_pend || $past(lvl_evt)));
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_int |=> (cause_ip != '0));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boundary) |-> $stable(cause_ip));
endmodule

bind irq_deliver irq_deliver_chk #(.LVL_W(LVL_W), .SR_W(SR_W), .IE_BIT(IE_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .lvl_evt(lvl_evt),
  .status(status), .cause_ip(cause_ip), .exc_int(exc_int),
  .exc_nmirst(exc_nmirst), .p_rst(p_rst), .p_nmi(p_nmi), .lvl_pend(lvl_pend)
);

// File: tb/irq_deliver_bench.sv
`timescale 1ns/1ps
module irq_deliver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_req = 1'b0, nmi_req = 1'b0, lvl_evt = 1'b0, boundary = 1'b0;
  logic [5:0]  lvl_in = '0;
  logic [31:0] status = '0;
  logic [5:0]  cause_ip;
  logic        exc_int, exc_nmirst;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_deliver u_irq_deliver (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
    .lvl_evt(lvl_evt), .lvl_in(lvl_in), .status(status), .boundary(boundary),
    .cause_ip(cause_ip), .exc_int(exc_int), .exc_nmirst(exc_nmirst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input logic ie, input logic [5:0] im);
    return {18'd0, im, 7'd0, ie};
  endfunction

  // {rst,nmi,lvl_evt, level[6], ie, im[6], exp_nmirst, exp_int, exp_cause[6]}
  localparam logic [23:0] VEC [12] = '{
    {3'b001, 6'h05, 1'b1, 6'h01, 1'b0, 1'b1, 6'h05}, // R6 deliver
    {3'b000, 6'h00, 1'b1, 6'h3f, 1'b0, 1'b0, 6'h05}, // R6 no longer pending
    {3'b001, 6'h0a, 1'b0, 6'h3f, 1'b0, 1'b0, 6'h0a}, // R7 disabled, R5 cause
    {3'b000, 6'h00, 1'b1, 6'h05, 1'b0, 1'b0, 6'h0a}, // R7 masked
    {3'b000, 6'h00, 1'b1, 6'h02, 1'b0, 1'b1, 6'h0a}, // R7 retried, delivered
    {3'b001, 6'h30, 1'b1, 6'h0f, 1'b0, 1'b0, 6'h30}, // R7 pending again
    {3'b001, 6'h00, 1'b1, 6'h3f, 1'b0, 1'b0, 6'h00}, // R8 end-of-interrupt
    {3'b000, 6'h00, 1'b1, 6'h3f, 1'b0, 1'b0, 6'h00}, // R8 cancelled
    {3'b011, 6'h01, 1'b1, 6'h3f, 1'b1, 1'b0, 6'h00}, // R3, R4 nmi first
    {3'b000, 6'h00, 1'b1, 6'h3f, 1'b0, 1'b1, 6'h01}, // R4 level after
    {3'b100, 6'h00, 1'b1, 6'h3f, 1'b1, 1'b0, 6'h01}, // R2 reset
    {3'b000, 6'h00, 1'b1, 6'h3f, 1'b0, 1'b0, 6'h01}  // R2 exactly once
  };

  task automatic events(input logic r, input logic n, input logic l, input logic [5:0] lv);
    @(negedge clk);
    rst_req = r; nmi_req = n; lvl_evt = l; lvl_in = lv; boundary = 1'b0;
    @(negedge clk);
    rst_req = 1'b0; nmi_req = 1'b0; lvl_evt = 1'b0;
  endtask

  task automatic strobe(input logic [31:0] st, output logic nr, output logic it, output logic [5:0] c);
    boundary = 1'b1; status = st;
    #1; nr = exc_nmirst; it = exc_int;
    @(negedge clk);
    boundary = 1'b0;
    #1; c = cause_ip;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic nr, it;
    logic [5:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cause", cause_ip, 0);
    chk("R1 exc_int", exc_int, 0);
    chk("R1 exc_nmirst", exc_nmirst, 0);
    @(negedge clk);
    strobe(sw(1'b1, 6'h3f), nr, it, c);
    chk("R1 idle boundary", {nr, it, c}, 0);

    for (int i = 0; i < 12; i++) begin
      logic [23:0] v;
      v = VEC[i];
      events(v[23], v[22], v[21], v[20:15]);
      strobe(sw(v[14], v[13:8]), nr, it, c);
      chk($sformatf("vec%0d exc_nmirst", i), nr, v[7]);
      chk($sformatf("vec%0d exc_int", i), it, v[6]);
      chk($sformatf("vec%0d cause R5", i), c, v[5:0]);
    end

    // R4: all three requests in one cycle
    events(1'b1, 1'b1, 1'b1, 6'h08);
    strobe(sw(1'b1, 6'h3f), nr, it, c);
    chk("R4 first reset", {nr, it, c}, {1'b1, 1'b0, 6'h01});
    strobe(sw(1'b1, 6'h3f), nr, it, c);
    chk("R4 second nmi", {nr, it, c}, {1'b1, 1'b0, 6'h01});
    strobe(sw(1'b1, 6'h3f), nr, it, c);
    chk("R4 third level", {nr, it, c}, {1'b0, 1'b1, 6'h08});

    // R9: overwrite while pending
    events(1'b0, 1'b0, 1'b1, 6'h02);
    events(1'b0, 1'b0, 1'b1, 6'h10);
    strobe(sw(1'b1, 6'h02), nr, it, c);
    chk("R9 old value masked", {nr, it, c}, {1'b0, 1'b0, 6'h10});
    strobe(sw(1'b1, 6'h10), nr, it, c);
    chk("R9 new value delivered", it, 1'b1);

    // R11 / R10: events with no boundary
    events(1'b1, 1'b1, 1'b1, 6'h3f);
    repeat (3) begin
      @(negedge clk); #1;
      chk("R11 no eval cause", cause_ip, 6'h10);
      chk("R10 no pulse off-boundary", {exc_int, exc_nmirst}, 2'b00);
    end
    strobe(sw(1'b1, 6'h3f), nr, it, c);
    chk("R2 after wait", {nr, it}, 2'b10);

    // R1: block reset clears pending state
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset cause", cause_ip, 0);
    @(negedge clk);
    strobe(sw(1'b1, 6'h3f), nr, it, c);
    chk("R1 pending dropped", {nr, it, c}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule